// File: doc/BRIEF.md
# Floating-Point Operand Alignment Stage

This block is the entry stage of a single-precision floating-point pipeline. It takes two 32-bit IEEE-754 words and an operation code, then produces one registered record for the arithmetic stage that follows. That record holds:

- the two 24-bit mantissas with the hidden bit restored;
- both signs;
- the result exponent;
- the operation code;
- two flags that describe how the operands were aligned.

For addition and subtraction, the exponents are compared with a single subtraction. The borrow of that subtraction shows which operand is larger. The smaller operand's mantissa is routed into a right shifter. The magnitude of the difference sets the shift distance. When the distance is too large for any bit to survive, alignment is skipped and the smaller mantissa is forced to zero.

For multiplication, no alignment takes place. The exponent becomes the biased sum of the two exponents, and both mantissas pass through unchanged.

The stage has one cycle of latency and can accept a new operand pair on every clock. It does not handle NaN, infinity or denormal encodings. Any operand whose exponent field is zero is treated as the value zero.

Top module: `fp_align_stage`

## Requirements
- R1: `out_valid` is `in_valid` delayed by one clock, so every accepted pair appears one cycle later. While reset is active, `out_valid` is 0 and every output field is 0.
- R2: Each operand word is split as sign = bit 31, exponent = bits 30:23, fraction = bits 22:0. A nonzero exponent gives the mantissa {1, fraction}. A zero exponent gives the mantissa 0, whatever the fraction.
- R3: For op codes other than multiply, `out_b_larger` is 1 exactly when B's exponent is strictly greater than A's. When the two exponents are equal it is 0, and A is treated as the larger operand.
- R4: For op codes other than multiply, `out_exp` is the larger of the two exponents, zero-extended to 10 bits.
- R5: For op codes other than multiply, when the exponent distance d = |EA − EB| is at most 23, the larger operand's mantissa is output unchanged. The smaller operand's mantissa is output shifted right by d, with zeros filled in from the top. Each mantissa stays in its own output: A's in `out_mant_a`, B's in `out_mant_b`.
- R6: For op codes other than multiply, when d is 24 or more, `out_gone` is 1, the smaller operand's mantissa output is 0, and the larger one is unchanged. When d is at most 23, `out_gone` is 0.
- R7: Op code 2'b10 is multiply. For it, `out_exp` = EA + EB − 127 as a 10-bit two's-complement value, both mantissas are output unshifted, and `out_gone` and `out_b_larger` are both 0.
- R8: Op codes 2'b00 (add), 2'b01 (subtract) and 2'b11 (spare) all align as in R3 to R6. The op code and both signs are copied unchanged to `out_op`, `out_sign_a` and `out_sign_b`.
- R9: In a cycle where `in_valid` is 0, no output field changes on the following clock, whatever is on the data inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_op | input | 2 | Operation code (00 add, 01 sub, 10 mul, 11 spare) |
| in_a | input | 32 | Operand A, IEEE-754 single |
| in_b | input | 32 | Operand B, IEEE-754 single |
| out_valid | output | 1 | Record valid |
| out_op | output | 2 | Copied operation code |
| out_sign_a | output | 1 | Sign of A |
| out_sign_b | output | 1 | Sign of B |
| out_exp | output | 10 | Result exponent, two's complement |
| out_mant_a | output | 24 | Mantissa of A, aligned if it was the smaller |
| out_mant_b | output | 24 | Mantissa of B, aligned if it was the smaller |
| out_b_larger | output | 1 | B has the strictly larger exponent |
| out_gone | output | 1 | Smaller mantissa fully shifted out |

## Verification
The bench targets the points where a careless design breaks:

- **Equal exponents.** A design that misreads the borrow would mark B as larger and shift the wrong operand.
- **Distances 23 and 24.** An off-by-one in the shift-out test would either lose the last surviving hidden bit or leave stray bits behind a flagged shift-out.
- **Zero exponents.** A design that keeps the hidden bit there would turn a zero operand into a mantissa of 1.0.
- **Multiply exponents.** Sums below and above the bias check that subtracting the bias wraps correctly in 10 bits.
- **Random pairs with nearby exponents.** These exercise every shifter stage and every routing choice.
- **Idle cycles with changing data.** These would expose a register that loads without `in_valid`.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
   typedef enum logic [1:0] {
      FPA_ADD = 2'b00,
      FPA_SUB = 2'b01,
      FPA_MUL = 2'b10,
      FPA_SPR = 2'b11
   } fpa_op_e;
endpackage

// File: rtl/fpa_unpack.sv
// Splits one IEEE-754 word and restores the hidden bit.
// A zero exponent field is taken to mean the value zero.
module fpa_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MANT_W = FRAC_W + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic              sign,
   output logic [EXP_W-1:0]  expo,
   output logic [MANT_W-1:0] mant
);
   logic [FRAC_W-1:0] frac;

   always_comb begin
      sign = word[WORD_W-1];
      expo = word[WORD_W-2 -: EXP_W];
      frac = word[FRAC_W-1:0];
      mant = (expo == '0) ? '0 : {1'b1, frac};
   end
endmodule

// File: rtl/fpa_exp_cmp.sv
// One subtraction does three jobs:
//   - its borrow picks the larger exponent,
//   - its magnitude is the shift distance,
//   - its size decides whether the smaller mantissa is lost entirely.
module fpa_exp_cmp #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SH_W  = $clog2(FRAC_W + 1)
) (
   input  logic [EXP_W-1:0] exp_a,
   input  logic [EXP_W-1:0] exp_b,
   output logic             b_larger,
   output logic [EXP_W-1:0] big_exp,
   output logic [SH_W-1:0]  shamt,
   output logic             gone
);
   logic [EXP_W:0]   diff;
   logic [EXP_W-1:0] mag;

   generate
      if (SH_W > EXP_W) begin : g_bad_width
         $error("fpa_exp_cmp: shift field wider than exponent");
      end
   endgenerate

   always_comb begin
      diff     = {1'b0, exp_a} - {1'b0, exp_b};
      b_larger = diff[EXP_W];
      mag      = b_larger ? (EXP_W'(0) - diff[EXP_W-1:0]) : diff[EXP_W-1:0];
      big_exp  = b_larger ? exp_b : exp_a;
      gone     = (mag > EXP_W'(FRAC_W));
      shamt    = mag[SH_W-1:0];
   end
endmodule

// File: rtl/fpa_rshift.sv
// Logical right shifter. BARREL=1 builds log2 stages, BARREL=0 leaves a
// single shift operator for the tool to map.
module fpa_rshift #(
   parameter int W      = 24,
   parameter int SH_W   = 5,
   parameter bit BARREL = 1'b1
) (
   input  logic [W-1:0]    din,
   input  logic [SH_W-1:0] sh,
   output logic [W-1:0]    dout
);
   generate
      if (BARREL) begin : g_barrel
         logic [W-1:0] stage [SH_W+1];
         assign stage[0] = din;
         for (genvar k = 0; k < SH_W; k++) begin : g_stage
            assign stage[k+1] = sh[k] ? (stage[k] >> (1 << k)) : stage[k];
         end
         assign dout = stage[SH_W];
      end else begin : g_flat
         assign dout = din >> sh;
      end
   endgenerate

   // R5: a zero shift distance must leave the mantissa unchanged
   always_comb begin
      if (sh == '0) begin
         p_zero_shift_ident_r5: assert (dout == din);
      end
   end
endmodule

// File: rtl/fp_align_stage.sv
module fp_align_stage #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int BIAS   = 127,
   parameter bit BARREL = 1'b1,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int MANT_W = FRAC_W + 1,
   localparam int SH_W   = $clog2(MANT_W),
   localparam int OEXP_W = EXP_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [WORD_W-1:0] in_a,
   input  logic [WORD_W-1:0] in_b,
   output logic              out_valid,
   output logic [1:0]        out_op,
   output logic              out_sign_a,
   output logic              out_sign_b,
   output logic [OEXP_W-1:0] out_exp,
   output logic [MANT_W-1:0] out_mant_a,
   output logic [MANT_W-1:0] out_mant_b,
   output logic              out_b_larger,
   output logic              out_gone
);
   import fpa_pkg::*;

   generate
      if (BIAS >= (1 << EXP_W)) begin : g_bad_bias
         $error("fp_align_stage: bias does not fit the exponent field");
      end
      if (FRAC_W >= (1 << EXP_W)) begin : g_bad_frac
         $error("fp_align_stage: fraction too wide for exponent range");
      end
   endgenerate

   logic              sgn [2];
   logic [EXP_W-1:0]  ex  [2];
   logic [MANT_W-1:0] mn  [2];
   logic [WORD_W-1:0] words [2];

   assign words[0] = in_a;
   assign words[1] = in_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_unpack
         fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
            .word (words[i]),
            .sign (sgn[i]),
            .expo (ex[i]),
            .mant (mn[i])
         );
      end
   endgenerate

   logic             b_larger, gone;
   logic [EXP_W-1:0] big_exp;
   logic [SH_W-1:0]  shamt;

   fpa_exp_cmp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cmp (
      .exp_a    (ex[0]),
      .exp_b    (ex[1]),
      .b_larger (b_larger),
      .big_exp  (big_exp),
      .shamt    (shamt),
      .gone     (gone)
   );

   // The borrow steers the smaller mantissa into the single shifter.
   logic [MANT_W-1:0] small_mant, shifted, aligned;

   assign small_mant = b_larger ? mn[0] : mn[1];

   fpa_rshift #(.W(MANT_W), .SH_W(SH_W), .BARREL(BARREL)) u_shift (
      .din  (small_mant),
      .sh   (shamt),
      .dout (shifted)
   );

   assign aligned = gone ? '0 : shifted;

   logic              is_mul;
   logic [MANT_W-1:0] nxt_ma, nxt_mb;
   logic [OEXP_W-1:0] nxt_exp;

   always_comb begin
      is_mul = (fpa_op_e'(in_op) == FPA_MUL);
      if (is_mul) begin
         nxt_ma  = mn[0];
         nxt_mb  = mn[1];
         nxt_exp = OEXP_W'(ex[0]) + OEXP_W'(ex[1]) - OEXP_W'(BIAS);
      end else begin
         nxt_ma  = b_larger ? aligned : mn[0];
         nxt_mb  = b_larger ? mn[1]   : aligned;
         nxt_exp = OEXP_W'(big_exp);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_op       <= '0;
         out_sign_a   <= 1'b0;
         out_sign_b   <= 1'b0;
         out_exp      <= '0;
         out_mant_a   <= '0;
         out_mant_b   <= '0;
         out_b_larger <= 1'b0;
         out_gone     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_op       <= in_op;
            out_sign_a   <= sgn[0];
            out_sign_b   <= sgn[1];
            out_exp      <= nxt_exp;
            out_mant_a   <= nxt_ma;
            out_mant_b   <= nxt_mb;
            out_b_larger <= b_larger & ~is_mul;
            out_gone     <= gone & ~is_mul;
         end
      end
   end

   // R1: an accepted pair appears on the next clock
   p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1: no record appears without an input pair
   p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9: idle cycles leave every field untouched
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_mant_a) && $stable(out_mant_b) &&
                     $stable(out_exp) && $stable(out_op)));
   // R6: a full shift-out leaves nothing of the smaller mantissa
   p_gone_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_gone |-> ((out_b_larger ? out_mant_a : out_mant_b) == '0));
   // R7: multiply never reports alignment flags
   p_mul_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b10) |=> (!out_gone && !out_b_larger));
   // R3: with equal exponents, A is taken as the larger operand
   p_equal_exp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op != 2'b10 && in_a[WORD_W-2 -: EXP_W] == in_b[WORD_W-2 -: EXP_W])
      |=> !out_b_larger);
endmodule

// File: tb/fp_align_stage_tb.sv
`timescale 1ns/1ps
module fp_align_stage_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [31:0] in_a = '0, in_b = '0;
   logic        out_valid, out_sign_a, out_sign_b, out_b_larger, out_gone;
   logic [1:0]  out_op;
   logic [9:0]  out_exp;
   logic [23:0] out_mant_a, out_mant_b;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   fp_align_stage u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_op(out_op),
      .out_sign_a(out_sign_a), .out_sign_b(out_sign_b), .out_exp(out_exp),
      .out_mant_a(out_mant_a), .out_mant_b(out_mant_b),
      .out_b_larger(out_b_larger), .out_gone(out_gone)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op,
                        output logic [9:0] e, output logic [23:0] ma, output logic [23:0] mb,
                        output logic bl, output logic gn);
      int ea, eb, d;
      ea = int'(a[30:23]);
      eb = int'(b[30:23]);
      ma = (ea == 0) ? 24'd0 : {1'b1, a[22:0]};
      mb = (eb == 0) ? 24'd0 : {1'b1, b[22:0]};
      bl = 1'b0;
      gn = 1'b0;
      if (op == 2'b10) begin
         e = 10'(ea + eb - 127);
      end else if (eb > ea) begin
         bl = 1'b1;
         d  = eb - ea;
         e  = 10'(eb);
         if (d > 23) begin gn = 1'b1; ma = '0; end
         else ma = ma >> d;
      end else begin
         d = ea - eb;
         e = 10'(ea);
         if (d > 23) begin gn = 1'b1; mb = '0; end
         else mb = mb >> d;
      end
   endtask

   task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [1:0] op);
      logic [9:0]  e;
      logic [23:0] ma, mb;
      logic        bl, gn;
      logic [9:0]  he;
      logic [23:0] hma, hmb;
      model(a, b, op, e, ma, mb, bl, gn);
      @(negedge clk);
      in_a = a; in_b = b; in_op = op; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 out_valid after accept", 64'(out_valid), 64'd1);
      chk("R2/R5/R7 mant_a", 64'(out_mant_a), 64'(ma));
      chk("R2/R5/R7 mant_b", 64'(out_mant_b), 64'(mb));
      chk("R4/R7 exponent", 64'(out_exp), 64'(e));
      chk("R3 b_larger", 64'(out_b_larger), 64'(bl));
      chk("R6 gone", 64'(out_gone), 64'(gn));
      chk("R8 op and signs", 64'({out_op, out_sign_a, out_sign_b}), 64'({op, a[31], b[31]}));
      he = out_exp; hma = out_mant_a; hmb = out_mant_b;
      in_a = ~a; in_b = a ^ b; in_op = ~op;
      @(negedge clk);
      chk("R1 no valid when idle", 64'(out_valid), 64'd0);
      chk("R9 hold while idle", 64'({he, hma, hmb}), 64'({out_exp, out_mant_a, out_mant_b}));
   endtask

   function automatic logic [31:0] mk(input logic s, input int e, input logic [22:0] f);
      return {s, 8'(e), f};
   endfunction

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [31:0] a, b;
      int ea, eb;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk("R1 reset valid", 64'(out_valid), 64'd0);
      chk("R1 reset fields", 64'({out_exp, out_mant_a, out_mant_b, out_gone}), 64'd0);
      rst_n = 1'b1;

      // Directed corners
      run(mk(0, 100, 23'h123456), mk(1, 100, 23'h654321), 2'b00); // R3 equal exponents
      run(mk(0, 80, 23'h7fffff), mk(0, 103, 23'h0), 2'b01);       // R5 distance 23
      run(mk(1, 130, 23'h0), mk(0, 107, 23'h7fffff), 2'b00);      // R5 distance 23, A larger
      run(mk(0, 80, 23'h7fffff), mk(0, 104, 23'h1), 2'b00);       // R6 distance 24
      run(mk(0, 200, 23'h1), mk(0, 0, 23'h7fffff), 2'b01);        // R2 zero operand, R6
      run(mk(0, 0, 23'h1), mk(0, 0, 23'h2), 2'b00);               // R2 both zero
      run(mk(0, 10, 23'h3), mk(0, 20, 23'h4), 2'b10);             // R7 exponent below bias
      run(mk(1, 254, 23'h7fffff), mk(1, 254, 23'h1), 2'b10);      // R7 large sum
      run(mk(0, 0, 23'h0), mk(0, 0, 23'h0), 2'b10);               // R7 minimum sum
      run(mk(1, 5, 23'h55), mk(0, 9, 23'haa), 2'b11);             // R8 spare code aligns

      // Random pairs, biased toward close exponents
      for (int n = 0; n < 400; n++) begin
         ea = int'($urandom_range(0, 255));
         if ($urandom_range(0, 3) != 0)
            eb = (ea + int'($urandom_range(0, 60)) - 30) & 255;
         else
            eb = int'($urandom_range(0, 255));
         a = mk(1'($urandom), ea, 23'($urandom));
         b = mk(1'($urandom), eb, 23'($urandom));
         run(a, b, 2'($urandom_range(0, 3)));
      end
      finish_up();
   end
endmodule